// File: doc/BRIEF.md
# Supervisory Reset Timer Controller

This block turns two reset causes into one system reset. The first cause is a digital "supply below threshold" flag that is already synchronous to the clock. The second is a manual request arriving on a shared open-drain reset pin. Reset is held for as long as the supply flag is set. Once the supply recovers, or once a valid manual request arrives, reset is stretched for a fixed number of clock cycles and then released.

The same pin carries the reset out of the block and the manual request into it. While reset is active the block pulls the pin low. When the timeout ends it lets go of the pin, and the external pull resistor sets the pin level. The pin input is synchronized and then filtered. A request counts only after the pin has been seen low for a minimum run of cycles, and only if the pin had been seen high since the block last drove it. A brief external press still gives the full timeout. Holding the pin low does not retrigger the timeout.

Top module: `rsv_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it rises, `sys_rst` and `pin_pull_low` are 1. They stay 1 until exactly TIMEOUT_CYCLES rising edges with `rst_n` high have passed.
- R2: Whenever `supply_low` is 1, `sys_rst` and `pin_pull_low` are 1 in the same cycle, with no clock edge needed.
- R3: After `supply_low` returns to 0, reset stays asserted for exactly TIMEOUT_CYCLES rising edges and then deasserts. This holds even if a manual timeout was already running.
- R4: A manual request is accepted after the pin has been sampled low on GLITCH_CYCLES consecutive rising edges. `sys_rst` then rises GLITCH_CYCLES+2 edges after the first low sample, because of the two synchronizer stages and the request register.
- R5: A low pulse on the pin spanning fewer than GLITCH_CYCLES rising edges does not assert reset.
- R6: An accepted manual request gives exactly TIMEOUT_CYCLES cycles of reset, however short the external pulse was.
- R7: `pin_pull_low` equals `sys_rst` at all times. When reset ends, the pin is released.
- R8: While the block pulls the pin low, pin activity is not a manual request. Pressing the pin during a running timeout does not extend it.
- R9: The manual input is edge sensitive. A pin held low past the end of the timeout does not start a new timeout until it has been seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own state |
| supply_low | input | 1 | Synchronous flag, 1 while the supply is below threshold |
| mr_pin_in | input | 1 | Level seen on the shared reset pin |
| pin_pull_low | output | 1 | 1 = drive the shared pin low (open-drain enable) |
| sys_rst | output | 1 | Active-high system reset |

## Verification
The bench builds the block with TIMEOUT_CYCLES = 12 and GLITCH_CYCLES = 3. With these values every manual pulse length from one cycle up to well past the timeout can be swept exhaustively. Each sweep step checks the exact cycle where reset rises and where it falls. The short values also bring within reach the exact filter boundary (pulse lengths 2 and 3), a re-press during a running timeout, a supply dip in the middle of a manual timeout, and a pin held low beyond the timeout. Expected levels come from the closed-form latencies stated in the requirements.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    localparam int unsigned DEF_TIMEOUT_CYCLES = 40_000_000;
    localparam int unsigned DEF_GLITCH_CYCLES  = 20;
    localparam int unsigned DEF_SYNC_STAGES    = 2;

    typedef enum logic {
        MR_DISARMED = 1'b0,
        MR_ARMED    = 1'b1
    } mr_arm_e;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/rsv_mr_filter.sv
module rsv_mr_filter
    import rsv_pkg::*;
#(
    parameter int unsigned GLITCH_CYCLES = DEF_GLITCH_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    input  logic self_drive,
    output logic mr_req
);
    localparam int unsigned LW = (GLITCH_CYCLES < 2) ? 1 : $clog2(GLITCH_CYCLES + 1);
    localparam logic [LW-1:0] LOW_LAST = LW'(GLITCH_CYCLES - 1);
    localparam logic [LW-1:0] LOW_SAT  = LW'(GLITCH_CYCLES);

    typedef struct packed {
        mr_arm_e         arm;
        logic [LW-1:0]   low_cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic     req_c;

    always_comb begin
        st_d  = st_q;
        req_c = 1'b0;
        if (self_drive) begin
            // Pin low is our own doing: disarm and forget any low run.
            st_d.arm     = MR_DISARMED;
            st_d.low_cnt = '0;
        end else if (pin_sync) begin
            st_d.arm     = MR_ARMED;
            st_d.low_cnt = '0;
        end else begin
            if (st_q.low_cnt != LOW_SAT) begin
                st_d.low_cnt = st_q.low_cnt + 1'b1;
            end
            if (st_q.arm == MR_ARMED && st_q.low_cnt == LOW_LAST) begin
                req_c    = 1'b1;
                st_d.arm = MR_DISARMED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.arm     <= MR_DISARMED;
            st_q.low_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mr_req = req_c;
endmodule

// File: rtl/rsv_timer.sv
module rsv_timer #(
    parameter int unsigned TIMEOUT_CYCLES = 40_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic mr_req,
    output logic busy
);
    localparam int unsigned CW = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (supply_low || mr_req) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/rsv_supervisor.sv
module rsv_supervisor
    import rsv_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = DEF_TIMEOUT_CYCLES,
    parameter int unsigned GLITCH_CYCLES  = DEF_GLITCH_CYCLES,
    parameter int unsigned SYNC_STAGES    = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic mr_pin_in,
    output logic pin_pull_low,
    output logic sys_rst
);
    logic pin_sync;
    logic mr_req;
    logic tmr_busy;
    logic rst_c;

    rsv_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mr_pin_in),
        .sync_out (pin_sync)
    );

    rsv_mr_filter #(
        .GLITCH_CYCLES (GLITCH_CYCLES)
    ) filt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sync   (pin_sync),
        .self_drive (rst_c),
        .mr_req     (mr_req)
    );

    rsv_timer #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .mr_req     (mr_req),
        .busy       (tmr_busy)
    );

    // Supply-low asserts reset without waiting for an edge.
    assign rst_c        = supply_low | tmr_busy;
    assign sys_rst      = rst_c;
    assign pin_pull_low = rst_c;
endmodule

// File: rtl/rsv_supervisor_chk.sv
module rsv_supervisor_chk #(
    parameter int unsigned TIMEOUT_CYCLES = 40_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic supply_low,
    input logic sys_rst,
    input logic pin_pull_low,
    input logic mr_req
);
    localparam int unsigned HW = $clog2(TIMEOUT_CYCLES + 2) + 1;
    localparam logic [HW-1:0] HOLD_EXP = HW'(TIMEOUT_CYCLES);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!sys_rst || supply_low) begin
            hold_q <= '0;
        end else if (hold_q != {HW{1'b1}}) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    AST_SUPPLY_FORCES_RST: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> (sys_rst && pin_pull_low)); // R2

    AST_SUPPLY_RECOVERY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_low) |-> sys_rst); // R3

    AST_REQ_ASSERTS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        mr_req |=> sys_rst); // R4

    AST_FULL_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (hold_q == HOLD_EXP)); // R6

    AST_NO_REQ_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pull_low |-> !mr_req); // R8
endmodule

bind rsv_supervisor rsv_supervisor_chk #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_low   (supply_low),
    .sys_rst      (sys_rst),
    .pin_pull_low (pin_pull_low),
    .mr_req       (mr_req)
);

// File: tb/rsv_supervisor_tb.sv
module rsv_supervisor_tb_top;
    localparam int T = 12;
    localparam int G = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0;
    logic ext_low = 1'b0;
    logic pin_level;
    logic pin_pull_low;
    logic sys_rst;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign pin_level = !(ext_low || pin_pull_low);

    rsv_supervisor #(
        .TIMEOUT_CYCLES (T),
        .GLITCH_CYCLES  (G),
        .SYNC_STAGES    (2)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low   (supply_low),
        .mr_pin_in    (pin_level),
        .pin_pull_low (pin_pull_low),
        .sys_rst      (sys_rst)
    );

    task automatic check(input logic exp, input string req);
        n_vec++;
        if (sys_rst !== exp || pin_pull_low !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t sys_rst=%b pin_pull_low=%b expected %b",
                     req, $time, sys_rst, pin_pull_low, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Manual pulse from idle: pin low on L sampled edges.
    task automatic manual_pulse(input int len);
        int win;
        logic exp;
        win = ((len > G + 2 + T) ? len : G + 2 + T) + 4;
        ext_low = 1'b1;
        for (int i = 1; i <= win; i++) begin
            step();
            if (i == len) ext_low = 1'b0;
            exp = (len >= G) && (i >= G + 2) && (i <= G + 1 + T);
            if (len < G)       check(exp, "R5");
            else if (len > T + G + 1) check(exp, "R9");
            else               check(exp, "R6");
        end
        ext_low = 1'b0;
        repeat (3) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: got running, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state and power-up timeout
        @(negedge clk);
        check(1'b1, "R1");
        repeat (2) step();
        check(1'b1, "R1");
        rst_n = 1'b1;
        for (int i = 1; i <= T + 3; i++) begin
            step();
            check(i < T, "R1");
        end
        repeat (3) step();

        // R4: exact latency of an accepted request
        ext_low = 1'b1;
        for (int i = 1; i <= G + 2 + T + 2; i++) begin
            step();
            if (i == G) ext_low = 1'b0;
            check((i >= G + 2) && (i <= G + 1 + T), "R4");
        end
        repeat (3) step();

        // R5, R6, R9: sweep of manual pulse lengths
        for (int len = 1; len <= T + G + 6; len++) begin
            manual_pulse(len);
        end

        // R2, R3: supply dips of several lengths
        for (int s = 1; s <= 5; s++) begin
            supply_low = 1'b1;
            #1;
            check(1'b1, "R2");
            for (int k = 1; k <= s; k++) begin
                step();
                check(1'b1, "R2");
            end
            supply_low = 1'b0;
            for (int i = 1; i <= T + 3; i++) begin
                step();
                check(i < T, "R3");
            end
            repeat (3) step();
        end

        // R3: supply dip during a running manual timeout restarts it
        ext_low = 1'b1;
        for (int i = 1; i <= G + 4; i++) begin
            step();
            if (i == G) ext_low = 1'b0;
        end
        check(1'b1, "R3");
        supply_low = 1'b1;
        repeat (2) step();
        supply_low = 1'b0;
        for (int i = 1; i <= T + 3; i++) begin
            step();
            check(i < T, "R3");
        end
        repeat (3) step();

        // R8: re-press during a running timeout does not extend it
        ext_low = 1'b1;
        for (int i = 1; i <= G + 4 + T; i++) begin
            step();
            if (i == G) ext_low = 1'b0;
            if (i == G + 5) ext_low = 1'b1;
            if (i == G + 5 + G + 1) ext_low = 1'b0;
            check((i >= G + 2) && (i <= G + 1 + T), "R8");
        end
        repeat (3) step();

        // R7: pin released and high after timeout
        n_vec++;
        if (pin_level !== 1'b1) begin
            n_bad++;
            $display("FAIL R7 pin level %b expected 1", pin_level);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule